// File: doc/BRIEF.md
# Hidden DAC Register Access Sequencer

This block sits on an 8-bit I/O bus in front of the palette pixel-mask register. It holds the mask register and a second, hidden register that shares the same port. The hidden register is invisible to ordinary software. It becomes reachable only after a run of consecutive reads of the mask port that no other bus access interrupts.

A small state machine counts those reads. While the count is below the unlock threshold, the mask port behaves normally. Once the threshold is reached, the next access to the mask port is steered to the hidden register. A read then returns the hidden value, and a write stores into the hidden register. Any access to another port clears the count, and so does any write. Idle bus cycles leave the count unchanged.

Each access is one clock cycle with a strobe. Read data is registered. It appears in the cycle after the read strobe and holds until the next read.

Top module: `hidden_dac_gate`

## Requirements
- R1: The block counts consecutive reads of the mask port (address 0x3C6). After 4 such reads it is armed. Cycles with neither strobe leave the count unchanged.
- R2: A read of any address other than 0x3C6 clears the count and returns 0x00.
- R3: A read of 0x3C6 with fewer than 4 counted reads returns the mask register and increments the count.
- R4: A read of 0x3C6 while armed returns the hidden register and clears the count. The following read of 0x3C6 returns the mask register again.
- R5: A write to 0x3C6 while armed stores the data in the hidden register and leaves the mask register unchanged.
- R6: A write to 0x3C6 while not armed stores the data in the mask register.
- R7: After any write, to any address, the count is zero.
- R8: Synchronous active-low reset sets the mask register to 0xFF, the hidden register to 0x00, the count to zero and the read data to 0x00.
- R9: Read data is registered. It changes on the clock edge that samples the read strobe and holds its value until the next read.
- R10: Read and write strobes must never be high in the same cycle. An assertion flags this case. If it happens anyway, the write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | I/O port address of the current access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The block is driven with uninterrupted runs of four, five and more mask-port reads. These show that exactly the fifth read reaches the hidden register, and that the sixth read falls back to the mask register. Runs broken by a read of another port, or by a write to another port, separate a counter that clears correctly from one that only saturates or ignores writes. Writes placed before and after the armed point show whether data lands in the hidden register or in the mask register. A follow-up read sequence then reads back both registers through the port. A long random mix of mask reads, foreign reads, writes and idle cycles, weighted toward mask reads, reaches the armed state many times from varied histories.

// File: rtl/hdac_pkg.sv
// Package: shared bus-operation type for the hidden DAC register gate.
// Assumes one access per cycle at most; the decoder collapses strobes into one op.
package hdac_pkg;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_RD_MASK  = 3'd1,
        OP_RD_OTHER = 3'd2,
        OP_WR_MASK  = 3'd3,
        OP_WR_OTHER = 3'd4
    } hdac_op_e;

    // True for either kind of write.
    function automatic logic op_is_write(hdac_op_e op);
        return (op == OP_WR_MASK) || (op == OP_WR_OTHER);
    endfunction

endpackage

// File: rtl/hdac_decoder.sv
// Module: classifies each bus cycle into one operation.
// Assumes read and write strobes are exclusive; if both are high, the write wins.
module hdac_decoder
    import hdac_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 16'h03C6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output hdac_op_e          op
);

    logic hit;

    // Compare the address against the mask port.
    assign hit = (addr == MASK_ADDR);

    // Collapse the strobes and the address hit into one operation code.
    always_comb begin
        if (wr)      op = hit ? OP_WR_MASK : OP_WR_OTHER;
        else if (rd) op = hit ? OP_RD_MASK : OP_RD_OTHER;
        else         op = OP_IDLE;
    end

    // R10: strobes must be exclusive.
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr));

endmodule

// File: rtl/hdac_seq_counter.sv
// Module: counts consecutive mask-port reads and raises 'armed' at the threshold.
// Assumes op comes from hdac_decoder; idle cycles keep the count.
module hdac_seq_counter
    import hdac_pkg::*;
#(
    parameter int UNLOCK_READS = 4,
    localparam int CNT_W = $clog2(UNLOCK_READS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  hdac_op_e         op,
    output logic [CNT_W-1:0] count,
    output logic             armed
);

    localparam logic [CNT_W-1:0] THRESH = CNT_W'(UNLOCK_READS);

    // Armed when the threshold of consecutive reads is reached.
    assign armed = (count == THRESH);

    // Advance, clear or hold the read count per operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (op)
                OP_RD_MASK:  count <= armed ? '0 : count + CNT_W'(1);
                OP_RD_OTHER: count <= '0;
                OP_WR_MASK:  count <= '0;
                OP_WR_OTHER: count <= '0;
                default:     count <= count;
            endcase
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= THRESH);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_IDLE |=> $stable(count));

    assert_other_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_RD_OTHER |=> count == '0);

    assert_mask_read_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RD_MASK && !armed) |=> count == $past(count) + CNT_W'(1));

    assert_armed_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RD_MASK && armed) |=> count == '0);

    assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_is_write(op) |=> count == '0);

endmodule

// File: rtl/hdac_regfile.sv
// Module: holds the mask and hidden registers and the registered read data.
// Assumes 'armed' reflects the count before the current access.
module hdac_regfile
    import hdac_pkg::*;
#(
    parameter int               DATA_W      = 8,
    parameter logic [DATA_W-1:0] MASK_RST   = 8'hFF,
    parameter logic [DATA_W-1:0] HIDDEN_RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hdac_op_e          op,
    input  logic              armed,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] hidden_q;

    // Steer a mask-port write to the hidden or the mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= MASK_RST;
            hidden_q <= HIDDEN_RST;
        end else if (op == OP_WR_MASK) begin
            if (armed) hidden_q <= wdata;
            else       mask_q   <= wdata;
        end
    end

    // Capture read data on read cycles only; foreign ports read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            case (op)
                OP_RD_MASK:  rdata <= armed ? hidden_q : mask_q;
                OP_RD_OTHER: rdata <= '0;
                default:     rdata <= rdata;
            endcase
        end
    end

    assert_other_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_RD_OTHER |=> rdata == '0);

    assert_mask_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RD_MASK && !armed) |=> rdata == $past(mask_q));

    assert_hidden_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RD_MASK && armed) |=> rdata == $past(hidden_q));

    assert_hidden_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WR_MASK && armed) |=> ($stable(mask_q) && hidden_q == $past(wdata)));

    assert_mask_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WR_MASK && !armed) |=> ($stable(hidden_q) && mask_q == $past(wdata)));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_RD_MASK && op != OP_RD_OTHER) |=> $stable(rdata));

endmodule

// File: rtl/hidden_dac_gate.sv
// Module: top of the hidden DAC register gate. A run of consecutive mask-port
// reads arms access to a hidden register behind the same port.
// Assumes single-cycle strobes, never both in one cycle.
module hidden_dac_gate
    import hdac_pkg::*;
#(
    parameter int                ADDR_W       = 16,
    parameter int                DATA_W       = 8,
    parameter logic [ADDR_W-1:0] MASK_ADDR    = 16'h03C6,
    parameter int                UNLOCK_READS = 4,
    parameter logic [DATA_W-1:0] MASK_RST     = 8'hFF,
    parameter logic [DATA_W-1:0] HIDDEN_RST   = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int CNT_W = $clog2(UNLOCK_READS + 1);

    hdac_op_e         op;
    logic [CNT_W-1:0] count;
    logic             armed;

    hdac_decoder #(
        .ADDR_W    (ADDR_W),
        .MASK_ADDR (MASK_ADDR)
    ) u_decoder (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .op   (op)
    );

    hdac_seq_counter #(
        .UNLOCK_READS(UNLOCK_READS)
    ) u_counter (
        .clk  (clk),
        .rst_n(rst_n),
        .op   (op),
        .count(count),
        .armed(armed)
    );

    hdac_regfile #(
        .DATA_W    (DATA_W),
        .MASK_RST  (MASK_RST),
        .HIDDEN_RST(HIDDEN_RST)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .op   (op),
        .armed(armed),
        .wdata(bus_wdata),
        .rdata(bus_rdata)
    );

    // R8: the first cycle after reset shows zero read data.
    assert_reset_rdata_R8: assert property (@(posedge clk)
        !rst_n |=> bus_rdata == '0);

endmodule

// File: tb/hidden_dac_gate_bench.sv
`timescale 1ns/1ps
module hidden_dac_gate_bench;

    localparam logic [15:0] MASK_PORT = 16'h03C6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;

    int tests = 0;
    int fails = 0;

    // Reference model state.
    int       m_cnt = 0;
    bit [7:0] m_mask = 8'hFF;
    bit [7:0] m_hidden = 8'h00;

    always #2.5 clk = ~clk;

    hidden_dac_gate u_hidden_dac_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // Expected read data for a read of addr, given the model state.
    function automatic bit [7:0] exp_read(logic [15:0] addr);
        if (addr != MASK_PORT) return 8'h00;
        return (m_cnt == 4) ? m_hidden : m_mask;
    endfunction

    // Requirement tag that a read of addr exercises.
    function automatic string read_tag(logic [15:0] addr);
        if (addr != MASK_PORT) return "R2";
        return (m_cnt == 4) ? "R4" : "R3";
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One read cycle; read data is sampled on the following falling edge.
    task automatic do_read(logic [15:0] addr, string tag = "");
        bit [7:0] e;
        string    t;
        e = exp_read(addr);
        t = (tag == "") ? read_tag(addr) : tag;
        if (addr != MASK_PORT) m_cnt = 0;
        else if (m_cnt == 4)   m_cnt = 0;
        else                   m_cnt++;
        @(negedge clk);
        bus_addr = addr; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(t, bus_rdata, e);
    endtask

    // One write cycle plus the model update.
    task automatic do_write(logic [15:0] addr, logic [7:0] data);
        if (addr == MASK_PORT) begin
            if (m_cnt == 4) m_hidden = data;
            else            m_mask   = data;
        end
        m_cnt = 0;
        @(negedge clk);
        bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    function automatic logic [15:0] other_port();
        logic [15:0] a;
        a = 16'h03C0 + 16'($urandom_range(0, 31));
        if (a == MASK_PORT) a = 16'h03C7;
        return a;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 rdata after reset", bus_rdata, 8'h00);
        do_read(MASK_PORT, "R8 mask reset");            // count 1
        repeat (3) do_read(MASK_PORT, "R3");             // count 4
        @(negedge clk); @(negedge clk);                  // idle keeps count (R1)
        do_read(MASK_PORT, "R1 R8 hidden reset after idle");
        do_read(MASK_PORT, "R4 back to mask");
        // Arm, write hidden, confirm mask untouched (R5).
        repeat (3) do_read(MASK_PORT);
        do_write(MASK_PORT, 8'h5A);
        do_read(MASK_PORT, "R6 ignored write not in mask");
        do_write(MASK_PORT, 8'h00);
        repeat (4) do_read(MASK_PORT);
        do_write(MASK_PORT, 8'hA5);
        do_read(MASK_PORT, "R5 mask unchanged");
        repeat (3) do_read(MASK_PORT);
        do_read(MASK_PORT, "R5 hidden written");
        // Plain mask write (R6).
        do_write(MASK_PORT, 8'h3C);
        do_read(MASK_PORT, "R6 mask written");
        // Interrupted run by foreign read (R2).
        repeat (2) do_read(MASK_PORT);
        do_read(16'h03C8, "R2 foreign read zero");
        repeat (4) do_read(MASK_PORT);
        do_read(MASK_PORT, "R4 after interrupt");
        // Interrupted by foreign write (R7).
        repeat (4) do_read(MASK_PORT);
        do_write(16'h03C9, 8'h77);
        do_read(MASK_PORT, "R7 foreign write clears");
        // R9: read data holds across idle and writes.
        do_write(16'h03D4, 8'h11);
        check("R9 hold", bus_rdata, m_mask);
        // Random mix.
        for (int i = 0; i < 4000; i++) begin
            int k;
            k = $urandom_range(0, 99);
            if (k < 70)      do_read(MASK_PORT);
            else if (k < 78) do_read(other_port());
            else if (k < 88) do_write(MASK_PORT, 8'($urandom));
            else if (k < 93) do_write(other_port(), 8'($urandom));
            else             @(negedge clk);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule